// File: doc/BRIEF.md
# Restoring Sequential Integer Divider

This block divides one W-bit integer by another (W = 32 by default) using restoring long division. Each quotient bit costs one clock cycle. In that cycle the partial remainder and the quotient move left together by one bit. The divisor is then subtracted as a trial. A negative difference clears the new quotient bit and adds the divisor back. A non-negative difference sets the quotient bit and keeps the difference. The partial remainder and the stored divisor are each one bit wider than the data, so the sign of the trial difference can be read directly from that extra bit.

A caller presents the dividend, the divisor and a signed-mode select, and raises `start` for one cycle while the unit is idle. Signed operands are reduced to magnitudes before the iterations start. The quotient and remainder signs are corrected on the cycle the unit completes. A zero divisor is detected when `start` is accepted and never enters the iteration loop. Results stay on the outputs until the next operation completes.

Top module: `restoring_divider`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy`, `done` and `div_zero` are 0 and `quotient` and `remainder` are 0.
- R2: A `start` accepted while `busy` is 0 with a non-zero divisor makes `busy` 1 on the next cycle. `busy` then stays 1 for exactly W cycles, and `done` is 1 on the cycle after the last of them.
- R3: With `signed_mode` = 0, operands are unsigned even when their top bit is 1. `quotient` is the floor of dividend/divisor, and `remainder` is dividend - quotient*divisor, which is always less than the divisor.
- R4: Boundary cases: a divisor larger than the dividend gives quotient 0 and remainder equal to the dividend. Equal operands give quotient 1 and remainder 0. 6 divided by 4 gives quotient 1 and remainder 2.
- R5: With `signed_mode` = 1, operands are two's complement. The quotient is the magnitude quotient, negated when the operand signs differ (truncation toward zero). The remainder has the magnitude remainder and the sign of the dividend.
- R6: With `signed_mode` = 1, the most negative dividend divided by -1 gives quotient equal to the most negative value (bit W-1 set, all other bits 0) and remainder 0, with no error indication.
- R7: A `start` accepted with divisor 0 raises `div_zero` and `done` on the next cycle. It gives `quotient` all ones and `remainder` equal to the dividend, and `busy` never rises for that operation.
- R8: `done` is 1 for exactly one cycle per operation. `quotient`, `remainder` and `div_zero` change only on a cycle where `done` is 1, and otherwise hold their values.
- R9: `start` raised while `busy` is 1 is ignored: the running operation finishes at its normal time with results computed from its own operands.
- R10: A completed operation with a non-zero divisor leaves `div_zero` at 0, even if the previous operation had set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; taken only while idle |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | W | Dividend, sampled when start is taken |
| divisor | input | W | Divisor, sampled when start is taken |
| quotient | output | W | Quotient of the last completed operation |
| remainder | output | W | Remainder of the last completed operation |
| div_zero | output | 1 | Last completed operation had a zero divisor |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- `done` is a single pulse and never coincides with `busy`.
- The busy interval lasts exactly W cycles.
- The outputs change only on a `done` cycle.
- A zero divisor completes on the next cycle with the fixed result pattern.
- Every unsigned result obeys quotient*divisor + remainder = dividend, with the remainder below the divisor.

Only the directed scenarios can show the following:
- The sign handling in signed mode, including the most-negative-by-minus-one case.
- The specific boundary quotients.
- That a `start` during the run leaves the result untouched.
- That `div_zero` clears again after a later operation.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rdiv_state_e;

    // Returns 1 when the trial difference in bit position msb is negative.
    function automatic logic trial_negative(input logic msb);
        return msb;
    endfunction
endpackage

// File: rtl/rdiv_operand_prep.sv
module rdiv_operand_prep #(
    parameter int W = 32
) (
    input  logic         signed_mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] mag_dividend,
    output logic [W-1:0] mag_divisor,
    output logic         neg_quot,
    output logic         neg_rem
);
    logic dvd_neg;
    logic dsr_neg;

    always_comb begin
        dvd_neg      = signed_mode & dividend[W-1];
        dsr_neg      = signed_mode & divisor[W-1];
        mag_dividend = dvd_neg ? (~dividend + W'(1)) : dividend;
        mag_divisor  = dsr_neg ? (~divisor + W'(1)) : divisor;
        neg_quot     = dvd_neg ^ dsr_neg;
        neg_rem      = dvd_neg;
    end
endmodule

// File: rtl/rdiv_step.sv
module rdiv_step
    import rdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W:0]   rem_in,
    input  logic [W-1:0] quo_in,
    input  logic [W:0]   dsr,
    output logic [W:0]   rem_out,
    output logic [W-1:0] quo_out
);
    logic [W:0]   shifted_rem;
    logic [W-1:0] shifted_quo;
    logic [W:0]   trial;

    always_comb begin
        // Shift the remainder and quotient left together by one bit.
        shifted_rem = {rem_in[W-1:0], quo_in[W-1]};
        shifted_quo = {quo_in[W-2:0], 1'b0};
        trial       = shifted_rem - dsr;
        if (trial_negative(trial[W])) begin
            // Restore by adding the divisor back; quotient bit stays 0.
            rem_out = trial + dsr;
            quo_out = shifted_quo;
        end else begin
            rem_out = trial;
            quo_out = {shifted_quo[W-1:1], 1'b1};
        end
    end
endmodule

// File: rtl/rdiv_sign_fix.sv
module rdiv_sign_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] mag_quot,
    input  logic [W-1:0] mag_rem,
    input  logic         neg_quot,
    input  logic         neg_rem,
    output logic [W-1:0] fix_quot,
    output logic [W-1:0] fix_rem
);
    always_comb begin
        fix_quot = neg_quot ? (~mag_quot + W'(1)) : mag_quot;
        fix_rem  = neg_rem  ? (~mag_rem  + W'(1)) : mag_rem;
    end
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
    import rdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_zero,
    output logic         busy,
    output logic         done
);
    localparam int CW = $clog2(W + 1);

    rdiv_state_e  state_q;
    logic [W:0]   rem_q;
    logic [W-1:0] quo_q;
    logic [W:0]   dsr_q;
    logic [CW-1:0] cnt_q;
    logic         negq_q;
    logic         negr_q;

    logic [W-1:0] mag_dvd;
    logic [W-1:0] mag_dsr;
    logic         negq_in;
    logic         negr_in;
    logic [W:0]   rem_nxt;
    logic [W-1:0] quo_nxt;
    logic [W-1:0] fix_quot;
    logic [W-1:0] fix_rem;

    rdiv_operand_prep #(.W(W)) u_prep (
        .signed_mode (signed_mode),
        .dividend    (dividend),
        .divisor     (divisor),
        .mag_dividend(mag_dvd),
        .mag_divisor (mag_dsr),
        .neg_quot    (negq_in),
        .neg_rem     (negr_in)
    );

    rdiv_step #(.W(W)) u_step (
        .rem_in (rem_q),
        .quo_in (quo_q),
        .dsr    (dsr_q),
        .rem_out(rem_nxt),
        .quo_out(quo_nxt)
    );

    rdiv_sign_fix #(.W(W)) u_fix (
        .mag_quot(quo_nxt),
        .mag_rem (rem_nxt[W-1:0]),
        .neg_quot(negq_q),
        .neg_rem (negr_q),
        .fix_quot(fix_quot),
        .fix_rem (fix_rem)
    );

    assign busy = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            rem_q     <= '0;
            quo_q     <= '0;
            dsr_q     <= '0;
            cnt_q     <= '0;
            negq_q    <= 1'b0;
            negr_q    <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
            div_zero  <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (divisor == '0) begin
                            quotient  <= '1;
                            remainder <= dividend;
                            div_zero  <= 1'b1;
                            done      <= 1'b1;
                        end else begin
                            rem_q   <= '0;
                            quo_q   <= mag_dvd;
                            dsr_q   <= {1'b0, mag_dsr};
                            cnt_q   <= CW'(W);
                            negq_q  <= negq_in;
                            negr_q  <= negr_in;
                            state_q <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    rem_q <= rem_nxt;
                    quo_q <= quo_nxt;
                    cnt_q <= cnt_q - CW'(1);
                    if (cnt_q == CW'(1)) begin
                        quotient  <= fix_quot;
                        remainder <= fix_rem;
                        div_zero  <= 1'b0;
                        done      <= 1'b1;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rdiv_chk.sv
module rdiv_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         signed_mode,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         div_zero,
    input logic         busy,
    input logic         done
);
    localparam int LW = $clog2(W + 2);

    logic [LW-1:0] busy_len;
    logic [W-1:0]  cap_dvd;
    logic [W-1:0]  cap_dsr;
    logic          cap_sgn;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_len <= '0;
            cap_dvd  <= '0;
            cap_dsr  <= '0;
            cap_sgn  <= 1'b0;
        end else begin
            busy_len <= busy ? busy_len + LW'(1) : '0;
            if (start && !busy) begin
                cap_dvd <= dividend;
                cap_dsr <= divisor;
                cap_sgn <= signed_mode;
            end
        end
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && !div_zero && quotient == '0 && remainder == '0));

    // R2
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && divisor != '0) |=> busy);

    // R2
    a_r2_busy_len: assert property (@(posedge clk) disable iff (rst)
        (done && !div_zero) |-> (busy_len == LW'(W)));

    // R8
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8
    a_r8_quot_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(quotient) |-> done);

    // R8
    a_r8_rem_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(remainder) |-> done);

    // R8
    a_r8_dz_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(div_zero) |-> done);

    // R7
    a_r7_zero_div: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && divisor == '0) |=>
            (done && div_zero && !busy && quotient == '1 && remainder == $past(dividend)));

    // R3
    a_r3_unsigned_identity: assert property (@(posedge clk) disable iff (rst)
        (done && !div_zero && !cap_sgn) |->
            (((2*W)'(quotient) * (2*W)'(cap_dsr) + (2*W)'(remainder)) == (2*W)'(cap_dvd)
             && remainder < cap_dsr));

    // R10
    a_r10_dz_clear: assert property (@(posedge clk) disable iff (rst)
        (done && cap_dsr != '0) |-> !div_zero);
endmodule

bind restoring_divider rdiv_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .signed_mode(signed_mode),
    .dividend   (dividend),
    .divisor    (divisor),
    .quotient   (quotient),
    .remainder  (remainder),
    .div_zero   (div_zero),
    .busy       (busy),
    .done       (done)
);

// File: tb/sim_restoring_divider.sv
module sim_restoring_divider;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;
    logic         div_zero;
    logic         busy;
    logic         done;

    int vectors = 0;
    int errors  = 0;

    always #10 clk = ~clk;

    restoring_divider #(.W(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
        .dividend(dividend), .divisor(divisor), .quotient(quotient),
        .remainder(remainder), .div_zero(div_zero), .busy(busy), .done(done)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected results from plain arithmetic on the operands.
    task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input logic sgn,
                         output logic [W-1:0] q, output logic [W-1:0] r);
        if (b == '0) begin
            q = '1;
            r = a;
        end else if (!sgn) begin
            q = a / b;
            r = a % b;
        end else if (a == {1'b1, {(W-1){1'b0}}} && b == '1) begin
            q = a;
            r = '0;
        end else begin
            q = W'($signed(a) / $signed(b));
            r = W'($signed(a) % $signed(b));
        end
    endtask

    // Issue one operation, optionally poke start mid-run, and check everything.
    task automatic run_div(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic sgn, input bit poke);
        logic [W-1:0] eq, er;
        int lat;
        model(a, b, sgn, eq, er);
        @(negedge clk);
        dividend = a; divisor = b; signed_mode = sgn; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        if (b != '0) check("R2", "busy after start", W'(busy), W'(1));
        while (!done && lat < 200) begin
            if (poke && lat == 3) begin
                dividend = 32'd99; divisor = 32'd7; signed_mode = 1'b0; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check(b == '0 ? "R7" : "R2", "latency", W'(lat), b == '0 ? W'(1) : W'(W + 1));
        check(req, "quotient", quotient, eq);
        check(req, "remainder", remainder, er);
        check(b == '0 ? "R7" : "R10", "div_zero", W'(div_zero), W'(b == '0));
        if (b == '0) check("R7", "busy never rises", W'(busy), W'(0));
        @(negedge clk);
        check("R8", "done pulse ends", W'(done), W'(0));
        check("R8", "quotient held", quotient, eq);
        check("R8", "remainder held", remainder, er);
    endtask

    task automatic t_reset();
        check("R1", "busy", W'(busy), W'(0));
        check("R1", "done", W'(done), W'(0));
        check("R1", "div_zero", W'(div_zero), W'(0));
        check("R1", "quotient", quotient, '0);
        check("R1", "remainder", remainder, '0);
    endtask

    task automatic t_unsigned();
        run_div("R3", 32'd1000, 32'd7, 1'b0, 1'b0);
        run_div("R3", 32'hFFFF_FFFF, 32'd3, 1'b0, 1'b0);
        run_div("R3", 32'h8000_0001, 32'hFFFF_FFF0, 1'b0, 1'b0);
        run_div("R3", 32'h1234_5678, 32'h0000_0101, 1'b0, 1'b0);
    endtask

    task automatic t_bounds();
        run_div("R4", 32'd6, 32'd4, 1'b0, 1'b0);
        run_div("R4", 32'd5, 32'd9, 1'b0, 1'b0);
        run_div("R4", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 1'b0);
        run_div("R4", 32'd77, 32'd1, 1'b0, 1'b0);
    endtask

    task automatic t_signed();
        run_div("R5", 32'hFFFF_FFF9, 32'd2, 1'b1, 1'b0);    // -7 / 2
        run_div("R5", 32'd7, 32'hFFFF_FFFE, 1'b1, 1'b0);    // 7 / -2
        run_div("R5", 32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b1, 1'b0); // -7 / -2
        run_div("R5", 32'd100, 32'd9, 1'b1, 1'b0);
    endtask

    task automatic t_minneg();
        run_div("R6", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0);
    endtask

    task automatic t_zero();
        run_div("R7", 32'h0BAD_F00D, 32'd0, 1'b0, 1'b0);
        run_div("R7", 32'hFFFF_FF00, 32'd0, 1'b1, 1'b0);
    endtask

    task automatic t_busy_start();
        run_div("R9", 32'd500, 32'd3, 1'b0, 1'b1);
    endtask

    task automatic t_dz_clear();
        run_div("R7", 32'd12, 32'd0, 1'b0, 1'b0);
        run_div("R10", 32'd12, 32'd5, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unsigned();
        t_bounds();
        t_signed();
        t_minneg();
        t_zero();
        t_busy_start();
        t_dz_clear();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule